// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles parity for one agent on a 32-bit multiplexed address/data bus clocked by the bus clock. It does not produce parity combinationally. It registers the even parity of the address/data and command/byte-enable lines and presents that value one clock later. The parity drive enable belongs to whichever agent owns each phase. The master owns the address phase and write data. The target owns read data.

On the receive side, the block samples the incoming parity bit one clock after a phase. It compares that bit against parity computed from the values it registered on the previous clock. Address errors, seen in the target role, produce a one-clock system-error pulse. Data errors are seen by the receiving agent on a completed and claimed data phase, and never on a special cycle. They drive the parity-error line low, then high for one clock, then release it.

Two sticky status bits record the two error kinds. A write-one-to-clear input clears them. The surrounding bus interface supplies the role and direction flags and owns the pads.

Top module: `pci_par_unit`

## Requirements
- R1: The parity output equals the XOR of all bits of `ad_i` and `cbe_n_i` as sampled at the previous rising edge. That makes the total count of ones over AD, C/BE# and PAR even.
- R2: In master role, `par_oe_o` is high in the clock after an address phase. An address phase is `frame_n_i` low while no transaction is open. In target role it stays low for that clock.
- R3: On writes, the master drives `par_oe_o` in each clock that follows a clock with `irdy_n_i` asserted. This holds across wait states, up to one clock after the completing phase. The target never drives on writes.
- R4: On reads, the target drives `par_oe_o` in each clock that follows a clock with `trdy_n_i` asserted. The master never drives on reads.
- R5: A data phase completes only at an edge where `irdy_n_i` and `trdy_n_i` are both low. Parity received for a wait-state clock is never checked.
- R6: The receiving agent checks the parity of each completed data phase. That agent is the target on writes (`is_master_i`=0, `is_read_i`=0) and the master on reads (both 1). It compares `par_i`, sampled one clock after completion, with the phase's parity. On a mismatch, `perr_oe_o`=1 with `perr_n_o`=0 is registered at the edge after that sample. The line is therefore seen low at the second rising edge after completion.
- R7: No data parity error is reported, and the status is not set, if `special_i` is high or `devsel_n_i` is high at the completing edge.
- R8: After a low PERR# clock that is not followed by a further error, PERR# is driven high (`perr_oe_o`=1, `perr_n_o`=1) for one clock and then released (`perr_oe_o`=0). Errors in back-to-back phases keep it low.
- R9: In target role, a mismatch of `par_i` one clock after the address phase raises `serr_oe_o` for exactly one clock, registered at the edge where `par_i` is sampled.
- R10: `sts_dpe_o` sets on a data error and `sts_ape_o` sets on an address error, and both hold. Writing 1 to `sts_clr_i[0]` clears the data bit and 1 to `sts_clr_i[1]` clears the address bit. A new error wins over a clear in the same clock.
- R11: During reset, `par_oe_o`, `perr_oe_o`, `serr_oe_o` and both status bits are low and `perr_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ad_i | input | ADW | Sampled address/data lines |
| cbe_n_i | input | BEW | Sampled command/byte-enable lines (active low) |
| par_i | input | 1 | Sampled parity line |
| frame_n_i | input | 1 | Sampled frame line (active low) |
| irdy_n_i | input | 1 | Sampled initiator-ready line (active low) |
| trdy_n_i | input | 1 | Sampled target-ready line (active low) |
| devsel_n_i | input | 1 | Sampled device-select line (active low) |
| is_master_i | input | 1 | 1 when this agent is the master of the transaction |
| is_read_i | input | 1 | 1 for a read transaction, 0 for a write |
| special_i | input | 1 | 1 when the current transaction is a special cycle |
| sts_clr_i | input | 2 | Write-one-to-clear: bit 0 data status, bit 1 address status |
| par_o | output | 1 | Generated parity value |
| par_oe_o | output | 1 | Parity drive enable |
| perr_n_o | output | 1 | Parity-error line value while driven |
| perr_oe_o | output | 1 | Parity-error drive enable |
| serr_oe_o | output | 1 | Open-drain system-error pull-down enable, one-clock pulse |
| sts_dpe_o | output | 1 | Sticky data parity error status |
| sts_ape_o | output | 1 | Sticky address parity error status |

## Verification
The bench builds the block with ADW=32 and BEW=4, so the lane tree has four byte lanes and covers the full 36-bit parity set. With these values the bench can run single-phase transactions, transactions with wait states, and two-phase bursts in every role and direction. It can also inject a wrong parity bit at a chosen clock. This puts within reach wait-state parity that must be ignored, back-to-back data errors, special-cycle and unclaimed suppression, and the clear-versus-set ordering of the status bits.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

  // Bit positions inside the status clear input.
  localparam int CLR_DPE_BIT = 0;
  localparam int CLR_APE_BIT = 1;

  // Per-clock phase qualifiers derived from the bus control lines.
  typedef struct packed {
    logic addr;     // address phase this clock
    logic xfer;     // data phase completes this clock
    logic claimed;  // device select asserted this clock
    logic special;  // special cycle in progress
  } phase_t;

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
  parameter int ADW = 32,
  parameter int BEW = 4
) (
  input  logic [ADW-1:0] ad_i,
  input  logic [BEW-1:0] cbe_n_i,
  output logic           par_o
);

  localparam int LANE = ADW / BEW;

  logic [BEW-1:0] lane_par;

  // One XOR tree per byte lane, folded with its enable bit.
  for (genvar g = 0; g < BEW; g++) begin : g_lane
    assign lane_par[g] = (^ad_i[g*LANE +: LANE]) ^ cbe_n_i[g];
  end

  assign par_o = ^lane_par;

endmodule

// File: rtl/pci_par_track.sv
module pci_par_track
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_n_i,
  input  logic   irdy_n_i,
  input  logic   trdy_n_i,
  input  logic   devsel_n_i,
  input  logic   special_i,
  input  logic   is_master_i,
  input  logic   is_read_i,
  input  logic   par_calc_i,
  output phase_t ph_o,
  output logic   par_o,
  output logic   par_oe_o
);

  logic busy_q, busy_d;
  logic par_q, par_d;
  logic oe_q, oe_d;
  logic irdy_act, trdy_act;

  always_comb begin
    irdy_act        = busy_q & ~irdy_n_i;
    trdy_act        = busy_q & ~trdy_n_i;
    ph_o.addr       = ~busy_q & ~frame_n_i;
    ph_o.xfer       = irdy_act & trdy_act;
    ph_o.claimed    = ~devsel_n_i;
    ph_o.special    = special_i;

    busy_d = busy_q;
    if (ph_o.addr) begin
      busy_d = 1'b1;
    end else if (busy_q && frame_n_i && irdy_n_i) begin
      busy_d = 1'b0;
    end

    // Parity value always lags the bus by one clock.
    par_d = par_calc_i;

    // Ownership of the parity line for the following clock.
    oe_d = (ph_o.addr & is_master_i)
         | (irdy_act & is_master_i & ~is_read_i)
         | (trdy_act & ~is_master_i & is_read_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      par_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      par_q  <= par_d;
      oe_q   <= oe_d;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
  import pci_par_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t ph_i,
  input  logic   is_master_i,
  input  logic   is_read_i,
  input  logic   par_calc_i,
  input  logic   par_i,
  output logic   addr_err_o,
  output logic   data_err_o
);

  logic calc_q, calc_d;
  logic achk_q, achk_d;
  logic dchk_q, dchk_d;
  logic rx_role;

  always_comb begin
    // Receiver of data: target on writes, master on reads.
    rx_role = (is_master_i == is_read_i);
    calc_d  = par_calc_i;
    achk_d  = ph_i.addr & ~is_master_i;
    dchk_d  = ph_i.xfer & ph_i.claimed & ~ph_i.special & rx_role;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_q <= 1'b0;
      achk_q <= 1'b0;
      dchk_q <= 1'b0;
    end else begin
      calc_q <= calc_d;
      achk_q <= achk_d;
      dchk_q <= dchk_d;
    end
  end

  assign addr_err_o = achk_q & (par_i ^ calc_q);
  assign data_err_o = dchk_q & (par_i ^ calc_q);

endmodule

// File: rtl/pci_par_report.sv
module pci_par_report
  import pci_par_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_err_i,
  input  logic       data_err_i,
  input  logic [1:0] sts_clr_i,
  output logic       perr_n_o,
  output logic       perr_oe_o,
  output logic       serr_oe_o,
  output logic       sts_dpe_o,
  output logic       sts_ape_o
);

  logic lo_q, lo_d;
  logic hi_q, hi_d;
  logic serr_q, serr_d;
  logic dpe_q, dpe_d, dpe_en;
  logic ape_q, ape_d, ape_en;

  always_comb begin
    lo_d   = data_err_i;
    hi_d   = lo_q & ~data_err_i;
    serr_d = addr_err_i;

    dpe_en = data_err_i | sts_clr_i[CLR_DPE_BIT];
    dpe_d  = data_err_i;
    ape_en = addr_err_i | sts_clr_i[CLR_APE_BIT];
    ape_d  = addr_err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      serr_q <= serr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpe_q <= 1'b0;
      ape_q <= 1'b0;
    end else begin
      if (dpe_en) dpe_q <= dpe_d;
      if (ape_en) ape_q <= ape_d;
    end
  end

  assign perr_n_o  = ~lo_q;
  assign perr_oe_o = lo_q | hi_q;
  assign serr_oe_o = serr_q;
  assign sts_dpe_o = dpe_q;
  assign sts_ape_o = ape_q;

endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
  import pci_par_pkg::*;
#(
  parameter int ADW = 32,
  parameter int BEW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [ADW-1:0] ad_i,
  input  logic [BEW-1:0] cbe_n_i,
  input  logic           par_i,
  input  logic           frame_n_i,
  input  logic           irdy_n_i,
  input  logic           trdy_n_i,
  input  logic           devsel_n_i,
  input  logic           is_master_i,
  input  logic           is_read_i,
  input  logic           special_i,
  input  logic [1:0]     sts_clr_i,
  output logic           par_o,
  output logic           par_oe_o,
  output logic           perr_n_o,
  output logic           perr_oe_o,
  output logic           serr_oe_o,
  output logic           sts_dpe_o,
  output logic           sts_ape_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       par_calc;
  phase_t     ph;
  logic       addr_err;
  logic       data_err;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  pci_par_tree #(.ADW(ADW), .BEW(BEW)) u_tree (
    .ad_i    (ad_i),
    .cbe_n_i (cbe_n_i),
    .par_o   (par_calc)
  );

  pci_par_track u_track (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .frame_n_i   (frame_n_i),
    .irdy_n_i    (irdy_n_i),
    .trdy_n_i    (trdy_n_i),
    .devsel_n_i  (devsel_n_i),
    .special_i   (special_i),
    .is_master_i (is_master_i),
    .is_read_i   (is_read_i),
    .par_calc_i  (par_calc),
    .ph_o        (ph),
    .par_o       (par_o),
    .par_oe_o    (par_oe_o)
  );

  pci_par_check u_check (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ph_i        (ph),
    .is_master_i (is_master_i),
    .is_read_i   (is_read_i),
    .par_calc_i  (par_calc),
    .par_i       (par_i),
    .addr_err_o  (addr_err),
    .data_err_o  (data_err)
  );

  pci_par_report u_report (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .addr_err_i (addr_err),
    .data_err_i (data_err),
    .sts_clr_i  (sts_clr_i),
    .perr_n_o   (perr_n_o),
    .perr_oe_o  (perr_oe_o),
    .serr_oe_o  (serr_oe_o),
    .sts_dpe_o  (sts_dpe_o),
    .sts_ape_o  (sts_ape_o)
  );

endmodule

// File: rtl/pci_par_sva.sv
module pci_par_sva #(
  parameter int ADW = 32,
  parameter int BEW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [ADW-1:0] ad_i,
  input logic [BEW-1:0] cbe_n_i,
  input logic           devsel_n_i,
  input logic [1:0]     sts_clr_i,
  input logic           par_o,
  input logic           par_oe_o,
  input logic           perr_n_o,
  input logic           perr_oe_o,
  input logic           serr_oe_o,
  input logic           sts_dpe_o,
  input logic           sts_ape_o
);

  AST_PAR_EVEN_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> (par_o == ^$past({ad_i, cbe_n_i}))); // R1

  AST_PERR_LOW_THEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe_o && !perr_n_o) |=> perr_oe_o); // R8

  AST_PERR_RELEASE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_oe_o) |-> $past(perr_n_o)); // R8

  AST_PERR_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe_o && !perr_n_o) |-> $past(!devsel_n_i, 2)); // R7

  AST_SERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe_o |=> !serr_oe_o); // R9

  AST_SERR_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe_o |-> sts_ape_o); // R10

  AST_DPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_dpe_o && !sts_clr_i[0]) |=> sts_dpe_o); // R10

  AST_APE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ape_o && !sts_clr_i[1]) |=> sts_ape_o); // R10

endmodule

bind pci_par_unit pci_par_sva #(.ADW(ADW), .BEW(BEW)) u_sva (.*);

// File: tb/pci_par_unit_bench.sv
`timescale 1ns/1ps
module pci_par_unit_bench;

  localparam int ADW = 32;
  localparam int BEW = 4;

  typedef enum int {S_PAR, S_PAROE, S_PERROE, S_PERRN, S_SERR, S_DPE, S_APE} sig_e;
  typedef struct {
    int    cyc;
    sig_e  sig;
    logic  exp;
    string req;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [ADW-1:0] ad_i = '0;
  logic [BEW-1:0] cbe_n_i = '1;
  logic           par_i = 1'b0;
  logic           frame_n_i = 1'b1;
  logic           irdy_n_i = 1'b1;
  logic           trdy_n_i = 1'b1;
  logic           devsel_n_i = 1'b1;
  logic           is_master_i = 1'b0;
  logic           is_read_i = 1'b0;
  logic           special_i = 1'b0;
  logic [1:0]     sts_clr_i = 2'b00;
  logic           par_o, par_oe_o, perr_n_o, perr_oe_o, serr_oe_o, sts_dpe_o, sts_ape_o;

  int   cyc = 0;
  int   tests = 0;
  int   fails = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  logic [ADW-1:0] last_ad = '0;
  logic [BEW-1:0] last_cbe = '1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pci_par_unit #(.ADW(ADW), .BEW(BEW)) u_pci_par_unit (.*);

  function automatic logic ep(input logic [ADW-1:0] a, input logic [BEW-1:0] c);
    return ^{a, c};
  endfunction

  function automatic logic got(input sig_e s);
    case (s)
      S_PAR:    return par_o;
      S_PAROE:  return par_oe_o;
      S_PERROE: return perr_oe_o;
      S_PERRN:  return perr_n_o;
      S_SERR:   return serr_oe_o;
      S_DPE:    return sts_dpe_o;
      default:  return sts_ape_o;
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic push(input int c, input sig_e s, input logic v, input string r);
    exp_t it;
    it.cyc = c; it.sig = s; it.exp = v; it.req = r;
    sb.push_back(it);
  endtask

  // Driver: one bus clock. par_i carries the parity of the previous clock, optionally flipped.
  task automatic bus_cycle(input logic fr, input logic ir, input logic tr, input logic dv,
                           input logic [ADW-1:0] ad, input logic [BEW-1:0] cbe,
                           input logic flip, input logic sp, input logic [1:0] clr,
                           output int e);
    @(negedge clk);
    frame_n_i = fr; irdy_n_i = ir; trdy_n_i = tr; devsel_n_i = dv;
    ad_i = ad; cbe_n_i = cbe; special_i = sp; sts_clr_i = clr;
    par_i = ep(last_ad, last_cbe) ^ flip;
    last_ad = ad; last_cbe = cbe;
    e = cyc + 1;
  endtask

  task automatic idle(input int n, input logic flip);
    int e;
    for (int i = 0; i < n; i++) begin
      bus_cycle(1, 1, 1, 1, 32'h0F0F_1234 + i, 4'hF, (i == 0) ? flip : 1'b0, 0, 2'b00, e);
    end
  endtask

  // Monitor: compare due expectations away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc == cyc) begin
          chk(got(sb[i].sig), sb[i].exp, sb[i].req, sb[i].sig.name());
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a, w, d, d2, c;
    // R11: reset state
    repeat (2) @(negedge clk);
    #5;
    chk(par_oe_o, 1'b0, "R11", "par_oe in reset");
    chk(perr_oe_o, 1'b0, "R11", "perr_oe in reset");
    chk(perr_n_o, 1'b1, "R11", "perr_n in reset");
    chk(serr_oe_o, 1'b0, "R11", "serr in reset");
    chk(sts_dpe_o | sts_ape_o, 1'b0, "R11", "status in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(4, 0);

    // Master write with one wait state: R1 R2 R3
    is_master_i = 1; is_read_i = 0;
    bus_cycle(0, 1, 1, 1, 32'h1000_0040, 4'b1000, 0, 0, 2'b00, a);
    push(a, S_PAROE, 1, "R2"); push(a, S_PAR, ep(32'h1000_0040, 4'b1000), "R1");
    bus_cycle(1, 0, 1, 0, 32'hDEAD_BEEF, 4'b0000, 0, 0, 2'b00, w);
    push(w, S_PAROE, 1, "R3"); push(w, S_PAR, ep(32'hDEAD_BEEF, 4'b0000), "R1");
    bus_cycle(1, 0, 0, 0, 32'hDEAD_BEEF, 4'b0000, 0, 0, 2'b00, d);
    push(d, S_PAROE, 1, "R3");
    idle(1, 0);
    push(d + 1, S_PAROE, 0, "R3"); push(d + 1, S_PERROE, 0, "R6");
    idle(2, 0);

    // Target write, wrong parity only on the wait-state clock: R5 R3
    is_master_i = 0; is_read_i = 0;
    bus_cycle(0, 1, 1, 1, 32'h2000_0000, 4'b0111, 0, 0, 2'b00, a);
    push(a, S_PAROE, 0, "R2");
    bus_cycle(1, 0, 1, 0, 32'h0000_0001, 4'b0000, 0, 0, 2'b00, w);
    push(w, S_SERR, 0, "R9"); push(w, S_PAROE, 0, "R3");
    bus_cycle(1, 0, 0, 0, 32'h0000_0001, 4'b0000, 1, 0, 2'b00, d);
    push(d, S_PERROE, 0, "R5"); push(d, S_PAROE, 0, "R3");
    idle(1, 0);
    push(d + 1, S_PERROE, 0, "R5"); push(d + 1, S_DPE, 0, "R5");
    idle(2, 0);

    // Target write, bad data parity: R6 R8 R10
    bus_cycle(0, 1, 1, 1, 32'h3000_0010, 4'b0111, 0, 0, 2'b00, a);
    bus_cycle(1, 0, 0, 0, 32'hA5A5_0F0F, 4'b0011, 0, 0, 2'b00, d);
    idle(1, 1);
    push(d + 1, S_PERROE, 1, "R6"); push(d + 1, S_PERRN, 0, "R6");
    push(d + 1, S_DPE, 1, "R10"); push(d + 1, S_APE, 0, "R10");
    push(d + 2, S_PERROE, 1, "R8"); push(d + 2, S_PERRN, 1, "R8");
    push(d + 3, S_PERROE, 0, "R8");
    idle(3, 0);

    // Target, bad address parity: R9 R10
    bus_cycle(0, 1, 1, 1, 32'h4000_0020, 4'b0110, 0, 0, 2'b00, a);
    bus_cycle(1, 0, 0, 0, 32'h1111_2222, 4'b0000, 1, 0, 2'b00, d);
    idle(1, 0);
    push(a + 1, S_SERR, 1, "R9"); push(a + 1, S_APE, 1, "R10");
    push(a + 2, S_SERR, 0, "R9"); push(a + 1, S_DPE, 1, "R10");
    push(d + 1, S_PERROE, 0, "R6");
    idle(2, 0);

    // Write-one-to-clear: R10
    bus_cycle(1, 1, 1, 1, 32'h0, 4'hF, 0, 0, 2'b01, c);
    push(c, S_DPE, 0, "R10"); push(c, S_APE, 1, "R10");
    bus_cycle(1, 1, 1, 1, 32'h0, 4'hF, 0, 0, 2'b10, c);
    push(c, S_APE, 0, "R10");
    idle(2, 0);

    // Special cycle with bad data parity: R7
    bus_cycle(0, 1, 1, 1, 32'h0, 4'b1110, 0, 1, 2'b00, a);
    bus_cycle(1, 0, 0, 0, 32'h5555_AAAA, 4'b0000, 0, 1, 2'b00, d);
    idle(1, 1);
    push(d + 1, S_PERROE, 0, "R7"); push(d + 1, S_DPE, 0, "R7");
    idle(2, 0);

    // Completion without device select, bad parity: R7
    bus_cycle(0, 1, 1, 1, 32'h5000_0000, 4'b0111, 0, 0, 2'b00, a);
    bus_cycle(1, 0, 0, 1, 32'h7777_8888, 4'b0000, 0, 0, 2'b00, d);
    idle(1, 1);
    push(d + 1, S_PERROE, 0, "R7"); push(d + 1, S_DPE, 0, "R7");
    idle(2, 0);

    // Target read: target drives read data parity, no check: R4 R2 R6
    is_master_i = 0; is_read_i = 1;
    bus_cycle(0, 1, 1, 1, 32'h6000_0004, 4'b0110, 0, 0, 2'b00, a);
    push(a, S_PAROE, 0, "R2");
    bus_cycle(1, 0, 1, 0, 32'h0, 4'b0000, 0, 0, 2'b00, w);
    push(w, S_PAROE, 0, "R4");
    bus_cycle(1, 0, 0, 0, 32'hC0DE_0001, 4'b0000, 0, 0, 2'b00, d);
    push(d, S_PAROE, 1, "R4"); push(d, S_PAR, ep(32'hC0DE_0001, 4'b0000), "R4");
    idle(1, 1);
    push(d + 1, S_PAROE, 0, "R4"); push(d + 1, S_PERROE, 0, "R6");
    idle(2, 0);

    // Master read, bad data parity: R4 R6 R8
    is_master_i = 1; is_read_i = 1;
    bus_cycle(0, 1, 1, 1, 32'h7000_0008, 4'b1001, 0, 0, 2'b00, a);
    push(a, S_PAROE, 1, "R2");
    bus_cycle(1, 0, 0, 0, 32'h1357_9BDF, 4'b0000, 0, 0, 2'b00, d);
    push(d, S_PAROE, 0, "R4");
    idle(1, 1);
    push(d + 1, S_PERROE, 1, "R6"); push(d + 1, S_PERRN, 0, "R6");
    push(d + 2, S_PERRN, 1, "R8"); push(d + 3, S_PERROE, 0, "R8");
    idle(3, 0);

    // Target write burst, both phases bad: R8
    is_master_i = 0; is_read_i = 0;
    bus_cycle(0, 1, 1, 1, 32'h8000_0000, 4'b0111, 0, 0, 2'b00, a);
    bus_cycle(0, 0, 0, 0, 32'hAAAA_0001, 4'b0000, 0, 0, 2'b00, d);
    bus_cycle(1, 0, 0, 0, 32'hAAAA_0002, 4'b0000, 1, 0, 2'b00, d2);
    idle(1, 1);
    push(d + 1, S_PERRN, 0, "R8"); push(d2 + 1, S_PERRN, 0, "R8");
    push(d2 + 1, S_PERROE, 1, "R8"); push(d2 + 2, S_PERRN, 1, "R8");
    push(d2 + 2, S_PERROE, 1, "R8"); push(d2 + 3, S_PERROE, 0, "R8");
    idle(5, 0);

    if (sb.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard (all requirements): actual=%0d pending expected=0", sb.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule